// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus. It gives a bus master byte access to a file of eight registers. The serial clock and data lines are sampled by a fast system clock through synchronizers. The block detects the bus start and stop conditions and compares the first byte of each transfer with its fixed device address. It acknowledges the bytes it receives and shifts register bytes out when the master reads. The data line is only ever pulled low, through an output enable. The bus pull-up supplies the high level.

On the register side the block presents a register pointer, write data, a one-cycle write strobe and a read-data input. In a write transfer, the first byte after the address loads the pointer. Each later byte is written to the register the pointer selects, and the pointer then advances. A read transfer streams bytes out starting at the current pointer, and the pointer advances after each byte. The pointer wraps from 7 to 0, and a transfer may carry any number of bytes. Loading the pointer and then issuing a repeated start with the read address gives a random-access read.

Top module: `tw_regslave`

## Requirements
- R1: Out of reset the data-line enable `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: A first byte of D0h (7-bit address 68h, write) or D1h (read) after a START is acknowledged: the slave holds the data line low for the whole high phase of the ninth clock.
- R3: A first byte with any other 7-bit address gets no acknowledge. The slave then neither acknowledges nor writes anything until the next START or STOP.
- R4: In a write transfer, the first byte after the address is acknowledged, and its three low bits become the register pointer. No write strobe is issued for it.
- R5: Each further byte of a write transfer is acknowledged and gives one single-cycle `reg_we` pulse with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. The pointer then rises by one, modulo 8.
- R6: In a read transfer the slave sends the register at the pointer most significant bit first, and the pointer advances by one (modulo 8) for every byte sent, so consecutive bytes come from consecutive registers.
- R7: When the master leaves the ninth bit of a read byte high, the slave sends no further byte and leaves the data line released until the next START or STOP.
- R8: A repeated START (START with no STOP before it) restarts address matching at once, including after an unmatched address.
- R9: The slave changes the data line only while the serial clock is low, and no sooner than `HOLD_CYC` system clocks after the serial clock falls.
- R10: A STOP releases the data line and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | REG_AW | Register pointer, used for both read and write |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
The bench writes runs of bytes that start near the top of the register file. A design that failed to wrap the pointer, or that wrote the pointer byte as data, would leave the wrong registers changed on read-back. Reads end with a master no-acknowledge, and random-access reads are built from repeated starts. A slave that kept driving after the no-acknowledge, or that needed a STOP to re-arm, would corrupt the read data or lose the acknowledge. Near-miss addresses such as D2h, followed by data bytes, catch a comparator that ignores an address bit or a slave that keeps writing after a mismatch. A monitor times every data-line change against the serial clock, which catches output updates made too early or while the clock is high.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_PTR,
      ST_WR,
      ST_RD,
      ST_SKIP
   } tws_state_e;

   localparam int BYTE_W  = 8;
   localparam int BIT_CW  = 4;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tws_sync: STAGES must be at least 2");
   end

   logic chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_events.sv
module tws_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_txhold.sv
module tws_txhold #(
   parameter int HOLD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic cancel,
   output logic upd
);
   localparam int CW = $clog2(HOLD_CYC + 1) + 1;

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("tws_txhold: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (cancel)        cnt <= '0;
      else if (fall)          cnt <= CW'(HOLD_CYC);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign upd = (cnt == CW'(1));
endmodule

// File: rtl/tw_regslave.sv
module tw_regslave #(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         REG_AW      = 3,
   parameter int         SYNC_STAGES = 2,
   parameter int         HOLD_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [REG_AW-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata
);
   import tws_pkg::*;

   if (REG_AW < 1 || REG_AW > 7) begin : g_bad_aw
      $error("tw_regslave: REG_AW must be 1..7");
   end

   logic scl_s, sda_s;
   logic ev_rise, ev_fall, ev_start, ev_stop, tx_upd;

   tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   tws_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(ev_rise), .scl_fall(ev_fall),
      .start_ev(ev_start), .stop_ev(ev_stop));

   tws_txhold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .fall(ev_fall),
      .cancel(ev_start | ev_stop), .upd(tx_upd));

   tws_state_e        state;
   logic [BIT_CW-1:0] bi;
   logic              rw;
   logic [REG_AW-1:0] ptr;
   logic [7:0]        shreg, rbyte;
   logic              oe_q, we_q;
   logic [7:0]        wdata_q;
   logic [7:0]        rx_byte;
   logic              ack_slot, rd_slot;

   assign rx_byte  = {shreg[6:0], sda_s};
   assign ack_slot = (state == ST_AACK || state == ST_PTR || state == ST_WR) && bi == 4'd8;
   assign rd_slot  = (state == ST_RD) && bi < 4'd8 && !rbyte[3'd7 - bi[2:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bi      <= '0;
         rw      <= 1'b0;
         ptr     <= '0;
         shreg   <= '0;
         rbyte   <= '0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         we_q <= 1'b0;
         if (we_q) ptr <= ptr + 1'b1;
         if (ev_start) begin
            state <= ST_ADDR;
            bi    <= '0;
            oe_q  <= 1'b0;
         end else if (ev_stop) begin
            state <= ST_IDLE;
            bi    <= '0;
            oe_q  <= 1'b0;
         end else begin
            if (ev_rise) begin
               case (state)
                  ST_ADDR, ST_PTR, ST_WR: begin
                     if (bi < 4'd8) begin
                        shreg <= rx_byte;
                        bi    <= bi + 1'b1;
                        if (bi == 4'd7) begin
                           if (state == ST_ADDR) begin
                              if (rx_byte[7:1] == DEV_ADDR) begin
                                 state <= ST_AACK;
                                 rw    <= rx_byte[0];
                              end else begin
                                 state <= ST_SKIP;
                              end
                           end else if (state == ST_PTR) begin
                              ptr <= rx_byte[REG_AW-1:0];
                           end else begin
                              we_q    <= 1'b1;
                              wdata_q <= rx_byte;
                           end
                        end
                     end else if (bi == 4'd8) begin
                        bi <= 4'd9;
                     end
                  end
                  ST_AACK: if (bi == 4'd8) bi <= 4'd9;
                  ST_RD: begin
                     if (bi < 4'd8)       bi <= bi + 1'b1;
                     else if (bi == 4'd8) begin
                        if (sda_s) state <= ST_SKIP;
                        else       bi    <= 4'd9;
                     end
                  end
                  default: ;
               endcase
            end
            if (ev_fall && bi == 4'd9) begin
               bi <= '0;
               case (state)
                  ST_AACK: state <= rw ? ST_RD : ST_PTR;
                  ST_PTR:  state <= ST_WR;
                  default: ;
               endcase
               if (state == ST_RD || (state == ST_AACK && rw)) begin
                  rbyte <= reg_rdata;
                  ptr   <= ptr + 1'b1;
               end
            end
            if (tx_upd) oe_q <= ack_slot | rd_slot;
         end
      end
   end

   assign sda_oe    = oe_q;
   assign reg_we    = we_q;
   assign reg_wdata = wdata_q;
   assign reg_addr  = ptr;
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
   parameter int REG_AW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic              start_ev,
   input logic              stop_ev
);
   AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we); // R5

   AST_PTR_STEP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr - $past(reg_addr)) == REG_AW'(1)); // R5

   AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i); // R9

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe); // R10

   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_oe); // R8
endmodule

bind tw_regslave tws_chk #(.REG_AW(REG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .reg_we(reg_we), .reg_addr(reg_addr),
   .start_ev(ev_start), .stop_ev(ev_stop));

// File: tb/tb_tw_regslave.sv
`timescale 1ns/1ps
module tb_tw_regslave;
   localparam int HOLD = 3;
   localparam int T    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_r = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_oe, reg_we;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic       sda_line;
   logic [7:0] rf  [8];
   logic [7:0] exp_rf [8];
   int total = 0, fails = 0, we_cnt = 0, hold_viol = 0, since_fall = 0;
   logic oe_prev = 1'b0, scl_prev = 1'b1, done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line  = ~(m_low | sda_oe);
   assign reg_rdata = rf[reg_addr];

   tw_regslave #(.DEV_ADDR(7'h68), .REG_AW(3), .SYNC_STAGES(2), .HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
      end else if (reg_we) begin
         rf[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   // R9 monitor: data-line changes only in the low phase, HOLD clocks after the fall
   always @(negedge clk) begin
      if (scl_prev && !scl_r) since_fall <= 0;
      else                    since_fall <= since_fall + 1;
      scl_prev <= scl_r;
      if (rst_n && sda_oe != oe_prev && (scl_r || since_fall < HOLD)) hold_viol <= hold_viol + 1;
      oe_prev <= sda_oe;
   end

   function automatic logic [2:0] ptr_after(input logic [2:0] p, input int n);
      return 3'((int'(p) + n) % 8);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic tq();
      repeat (T) @(negedge clk);
   endtask

   task automatic bus_start();
      tq(); m_low = 1'b0; tq(); scl_r = 1'b1; tq(); m_low = 1'b1; tq(); scl_r = 1'b0; tq();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tq(); scl_r = 1'b1; tq(); m_low = 1'b0; tq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         tq(); m_low = ~b[i]; tq(); scl_r = 1'b1; tq(); tq(); scl_r = 1'b0;
      end
      tq(); m_low = 1'b0; tq(); scl_r = 1'b1; tq(); ack = ~sda_line; tq(); scl_r = 1'b0;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tq(); tq(); scl_r = 1'b1; tq(); b[i] = sda_line; tq(); scl_r = 1'b0;
      end
      tq(); m_low = give_ack; tq(); scl_r = 1'b1; tq(); tq(); scl_r = 1'b0; tq(); m_low = 1'b0;
   endtask

   task automatic do_write(input logic [2:0] p, input int n, input logic [7:0] d [8]);
      logic a;
      bus_start();
      send_byte(8'hD0, a); check(a, "R2 write address ack", a, 1);
      send_byte({5'b0, p}, a); check(a, "R4 pointer byte ack", a, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], a); check(a, "R5 data byte ack", a, 1);
         exp_rf[ptr_after(p, i)] = d[i];
      end
      bus_stop();
      check(reg_addr == ptr_after(p, n), "R5 pointer after writes", reg_addr, ptr_after(p, n));
   endtask

   task automatic do_read(input logic [2:0] p, input int n);
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD0, a); check(a, "R2 address ack", a, 1);
      send_byte({5'b0, p}, a); check(a, "R4 pointer ack", a, 1);
      bus_start();
      send_byte(8'hD1, a); check(a, "R8 repeated start read address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         check(b == exp_rf[ptr_after(p, i)], "R6 read byte", b, exp_rf[ptr_after(p, i)]);
      end
      tq();
      check(sda_oe == 1'b0, "R7 released after master nack", sda_oe, 0);
      check(reg_addr == ptr_after(p, n), "R6 pointer after reads", reg_addr, ptr_after(p, n));
      bus_stop();
      check(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
   endtask

   initial begin
      logic       a;
      logic [7:0] d [8];
      int         wc;
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < 8; i++) exp_rf[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
      check(reg_we == 1'b0, "R1 reset reg_we", reg_we, 0);
      check(reg_addr == 3'd0, "R1 reset reg_addr", reg_addr, 0);

      // directed: write crossing the wrap point
      d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
      for (int i = 4; i < 8; i++) d[i] = 8'h00;
      do_write(3'd5, 4, d);
      for (int i = 0; i < 8; i++)
         check(rf[i] == exp_rf[i], "R5 register file after wrap write", rf[i], exp_rf[i]);

      // directed: read across wrap with nack on last byte
      do_read(3'd6, 3);

      // directed: mismatched addresses are ignored
      wc = we_cnt;
      bus_start();
      send_byte(8'hD2, a); check(!a, "R3 near-miss address not acked", a, 0);
      send_byte(8'h01, a); check(!a, "R3 byte after mismatch not acked", a, 0);
      send_byte(8'h5A, a); check(!a, "R3 second byte after mismatch not acked", a, 0);
      bus_stop();
      check(we_cnt == wc, "R3 no write after mismatch", we_cnt, wc);
      check(rf[1] == exp_rf[1], "R3 register untouched", rf[1], exp_rf[1]);

      // directed: mismatch then repeated START with matching address
      bus_start();
      send_byte(8'hA0, a); check(!a, "R3 foreign address not acked", a, 0);
      bus_start();
      send_byte(8'hD0, a); check(a, "R8 repeated start rematches", a, 1);
      send_byte(8'h02, a); check(a, "R4 pointer after repeated start", a, 1);
      send_byte(8'h9C, a); check(a, "R5 data after repeated start", a, 1);
      exp_rf[2] = 8'h9C;
      bus_stop();
      check(rf[2] == 8'h9C, "R5 written via repeated start", rf[2], 8'h9C);
      check(we_cnt == wc + 1, "R4 pointer byte not written", we_cnt, wc + 1);

      // constrained random transfers
      for (int it = 0; it < 14; it++) begin
         logic [2:0] p;
         int n;
         p = 3'($urandom % 8);
         n = 1 + int'($urandom % 6);
         for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
         do_write(p, n, d);
         p = 3'($urandom % 8);
         do_read(p, 1 + int'($urandom % 6));
      end

      check(hold_viol == 0, "R9 data-line change timing", hold_viol, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule